// File: doc/BRIEF.md
# Byte-Command Serial EEPROM Bus Master

This block is a two-wire serial bus master for an external EEPROM. Firmware controls it through two write targets: a data byte and a control word. It first writes the byte to send into the data target. It then writes a command code into the control word, and that write starts the bus operation. While the operation runs, the block drives the clock line and pulls the open-drain data line low when needed. It then reports the outcome in a status byte.

There are five operations: a start condition, a stop condition, sending one byte, and receiving one byte. A receive can end either with an acknowledge or with a no-acknowledge from the master. Bit timing comes from a parameter, `QUARTER`, which sets how many clock cycles each quarter of a bus bit lasts. A start or stop therefore takes 4·QUARTER cycles, and a byte transfer with its acknowledge slot takes 36·QUARTER cycles. The block does not support arbitration between masters or clock stretching by the slave.

Top module: `eeprom_i2c_master`

## Requirements
- R1: After reset, the status byte reads 0x30, the data byte reads 0x00, the clock line is high and the data line is released.
- R2: The status byte holds the following fields:
  - bits [3:0]: the last command code written while idle;
  - bit 4: transmit-acknowledge, active low;
  - bit 5: receive-acknowledge, active low;
  - bit 6: busy;
  - bit 7: error.
  The command codes are 0x1 start, 0x2 stop, 0x3 send byte, 0x4 receive byte with acknowledge, and 0x5 receive byte with no-acknowledge.
- R3: A start command pulls the data line low while the clock is high, takes 4·QUARTER cycles, and ends with the clock high and the data line low. It also works as a repeated start after a byte.
- R4: A stop command releases the data line while the clock is high, takes 4·QUARTER cycles, and leaves the bus idle.
- R5: A send-byte command does the following:
  - it gives nine clock pulses and takes 36·QUARTER cycles;
  - it presents the data byte MSB first on the first eight pulses;
  - it releases the data line for the ninth pulse;
  - it changes the data line only while the clock is low.
- R6: After a send-byte command, the receive-acknowledge bit equals the data line level sampled at the ninth rising clock edge. It reads 0 when the EEPROM acknowledged.
- R7: A receive command samples the data line on eight rising clock edges, MSB first. The received byte appears in the data byte in the same cycle that busy clears.
- R8: During the ninth pulse of a receive, command 0x4 drives the data line low and command 0x5 releases it. Afterwards the transmit-acknowledge bit reads 0 after 0x4 and 1 after 0x5.
- R9: Busy reads 1 from the cycle after a legal command is written until the operation ends. The clock line is high whenever busy is 0.
- R10: An illegal code (0x0 or 0x6 to 0xF) sets the error bit and starts no bus activity. A legal command written while idle clears the error bit.
- R11: While busy, writes to the control word are ignored and set the error bit. Writes to the data byte are also ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, one cycle |
| wrCtrl | input | 1 | Write target: 1 selects the control word, 0 selects the data byte |
| wrData | input | 8 | Write value; the command code is in bits [3:0] |
| dataOut | output | 8 | Data byte |
| statusOut | output | 8 | Status byte (layout in R2) |
| sclOut | output | 1 | Bus clock line |
| sdaPullLow | output | 1 | 1 pulls the open-drain data line low |
| sdaIn | input | 1 | Data line level as seen on the bus |

## Verification
The bench builds the block with QUARTER = 2, so each byte transfer takes 72 cycles. At that length every one of the 256 byte values can be sent, and every one can also be received. The sends alternate between an EEPROM acknowledge and a no-acknowledge, and the receives alternate between the two receive commands. A bus model in the bench captures the data line at each rising clock edge and counts start and stop conditions. With it, every bit position, both acknowledge polarities, all eleven illegal codes and writes made during a transfer are all reached.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam logic [3:0] CMD_START   = 4'h1;
  localparam logic [3:0] CMD_STOP    = 4'h2;
  localparam logic [3:0] CMD_TX      = 4'h3;
  localparam logic [3:0] CMD_RX_ACK  = 4'h4;
  localparam logic [3:0] CMD_RX_NACK = 4'h5;

  // What the data line register does on a phase entry
  typedef enum logic [1:0] {
    DRV_KEEP  = 2'd0,
    DRV_LOW   = 2'd1,
    DRV_REL   = 2'd2,
    DRV_SHIFT = 2'd3
  } drv_e;

  typedef struct packed {
    logic loadShift;
    logic dataWr;
    drv_e drv;
    logic shiftIn;
    logic ackSample;
    logic commit;
    logic txAckWr;
    logic txAckVal;
  } strobes_t;

endpackage

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int QUARTER = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrCtrl,
  input  logic [3:0] code,
  output strobes_t   st,
  output logic       busy,
  output logic       sclHigh,
  output logic       error,
  output logic [3:0] cmdField
);

  localparam int CNT_W = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUARTER - 1);
  localparam logic [3:0] BYTE_LAST = 4'd8;

  logic [CNT_W-1:0] divCnt;
  logic [1:0]       phase;
  logic [3:0]       slot;
  logic [3:0]       op;

  logic tick, ctrlWr, isLegal, isRx, isByteOp, atLast, dataSlot;

  assign tick     = busy && (divCnt == CNT_LAST);
  assign ctrlWr   = wrEn && wrCtrl;
  assign isLegal  = (code >= CMD_START) && (code <= CMD_RX_NACK);
  assign isRx     = (op == CMD_RX_ACK) || (op == CMD_RX_NACK);
  assign isByteOp = isRx || (op == CMD_TX);
  assign atLast   = isByteOp ? (slot == BYTE_LAST) : (slot == 4'd0);
  assign dataSlot = slot < BYTE_LAST;
  assign sclHigh  = !busy || phase[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      divCnt   <= '0;
      phase    <= 2'd0;
      slot     <= 4'd0;
      op       <= 4'd0;
      error    <= 1'b0;
      cmdField <= 4'd0;
    end else begin
      if (ctrlWr && busy) error <= 1'b1;
      if (ctrlWr && !busy) begin
        cmdField <= code;
        error    <= !isLegal;
        if (isLegal) begin
          busy   <= 1'b1;
          op     <= code;
          divCnt <= '0;
          phase  <= 2'd0;
          slot   <= 4'd0;
        end
      end else if (busy) begin
        if (tick) begin
          divCnt <= '0;
          phase  <= phase + 2'd1;
          if (phase == 2'd3) begin
            if (atLast) busy <= 1'b0;
            else        slot <= slot + 4'd1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    st           = '0;
    st.drv       = DRV_KEEP;
    st.loadShift = ctrlWr && !busy && (code == CMD_TX);
    st.dataWr    = wrEn && !wrCtrl && !busy;
    if (tick) begin
      unique case (phase)
        2'd0: begin
          unique case (op)
            CMD_START:   st.drv = DRV_REL;
            CMD_STOP:    st.drv = DRV_LOW;
            CMD_TX:      st.drv = dataSlot ? DRV_SHIFT : DRV_REL;
            CMD_RX_ACK:  st.drv = dataSlot ? DRV_REL : DRV_LOW;
            default:     st.drv = DRV_REL;
          endcase
        end
        2'd1: begin
          if (isByteOp && dataSlot)          st.shiftIn   = 1'b1;
          else if (isByteOp && op == CMD_TX) st.ackSample = 1'b1;
        end
        2'd2: begin
          if (op == CMD_START)     st.drv = DRV_LOW;
          else if (op == CMD_STOP) st.drv = DRV_REL;
        end
        default: begin
          if (atLast && isRx) begin
            st.commit   = 1'b1;
            st.txAckWr  = 1'b1;
            st.txAckVal = (op == CMD_RX_NACK);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobes_t   st,
  input  logic [7:0] wrData,
  input  logic       sdaIn,
  output logic [7:0] dataReg,
  output logic       sdaLow,
  output logic       rxAckN,
  output logic       txAckN
);

  logic [7:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= 8'h00;
      shiftReg <= 8'h00;
      sdaLow   <= 1'b0;
      rxAckN   <= 1'b1;
      txAckN   <= 1'b1;
    end else begin
      if (st.dataWr)      dataReg <= wrData;
      else if (st.commit) dataReg <= shiftReg;

      if (st.loadShift)    shiftReg <= dataReg;
      else if (st.shiftIn) shiftReg <= {shiftReg[6:0], sdaIn};

      unique case (st.drv)
        DRV_LOW:   sdaLow <= 1'b1;
        DRV_REL:   sdaLow <= 1'b0;
        DRV_SHIFT: sdaLow <= !shiftReg[7];
        default:   sdaLow <= sdaLow;
      endcase

      if (st.ackSample) rxAckN <= sdaIn;
      if (st.txAckWr)   txAckN <= st.txAckVal;
    end
  end

endmodule

// File: rtl/eeprom_i2c_master.sv
module eeprom_i2c_master
  import i2cm_pkg::*;
#(
  parameter int QUARTER = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrCtrl,
  input  logic [7:0] wrData,
  output logic [7:0] dataOut,
  output logic [7:0] statusOut,
  output logic       sclOut,
  output logic       sdaPullLow,
  input  logic       sdaIn
);

  strobes_t   st;
  logic       busy, error, rxAckN, txAckN;
  logic [3:0] cmdField;

  i2cm_ctrl #(.QUARTER(QUARTER)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrCtrl   (wrCtrl),
    .code     (wrData[3:0]),
    .st       (st),
    .busy     (busy),
    .sclHigh  (sclOut),
    .error    (error),
    .cmdField (cmdField)
  );

  i2cm_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .wrData  (wrData),
    .sdaIn   (sdaIn),
    .dataReg (dataOut),
    .sdaLow  (sdaPullLow),
    .rxAckN  (rxAckN),
    .txAckN  (txAckN)
  );

  assign statusOut = {error, busy, rxAckN, txAckN, cmdField};

endmodule

// File: rtl/eeprom_i2c_master_checker.sv
module eeprom_i2c_master_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       wrCtrl,
  input logic [3:0] wrCode,
  input logic [7:0] dataOut,
  input logic [3:0] cmdField,
  input logic       busy,
  input logic       error,
  input logic       sclOut,
  input logic       sdaPullLow
);

  logic illegalCode;
  assign illegalCode = (wrCode == 4'h0) || (wrCode > 4'h5);

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclOut && $past(sclOut) && (sdaPullLow != $past(sdaPullLow)))
      |-> (cmdField == 4'h1 || cmdField == 4'h2)); // R5

  AST_IDLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sclOut); // R9

  AST_LEGAL_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrCtrl && !busy && !illegalCode) |=> (busy && !error)); // R9

  AST_ILLEGAL_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrCtrl && !busy && illegalCode) |=> (!busy && error)); // R10

  AST_BUSY_WRITE_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrCtrl && busy) |=> error); // R11

  AST_DATA_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(dataOut)); // R11

endmodule

bind eeprom_i2c_master eeprom_i2c_master_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrCtrl     (wrCtrl),
  .wrCode     (wrData[3:0]),
  .dataOut    (dataOut),
  .cmdField   (statusOut[3:0]),
  .busy       (statusOut[6]),
  .error      (statusOut[7]),
  .sclOut     (sclOut),
  .sdaPullLow (sdaPullLow)
);

// File: tb/eeprom_i2c_master_bench.sv
`timescale 1ns/1ps
module eeprom_i2c_master_bench;

  localparam int Q = 2;
  localparam int SHORT_CYC = 4 * Q;
  localparam int BYTE_CYC = 36 * Q;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic wrCtrl = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] dataOut, statusOut;
  logic sclOut, sdaPullLow;
  logic slaveLow = 1'b0;
  logic sdaBus;

  int checks = 0;
  int errors = 0;

  // bus model state
  logic [8:0] slaveBits = 9'h1FF;
  int negIdx = 0;
  logic [8:0] cap = 9'h0;
  int capCnt = 0;
  int starts = 0;
  int stops = 0;

  always #10 clk = ~clk;

  assign sdaBus = !(sdaPullLow || slaveLow);

  eeprom_i2c_master #(.QUARTER(Q)) u_eeprom_i2c_master (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCtrl(wrCtrl), .wrData(wrData),
    .dataOut(dataOut), .statusOut(statusOut), .sclOut(sclOut),
    .sdaPullLow(sdaPullLow), .sdaIn(sdaBus)
  );

  always @(negedge sclOut) begin
    negIdx = negIdx + 1;
    slaveLow <= (negIdx >= 1 && negIdx <= 9) ? !slaveBits[9 - negIdx] : 1'b0;
  end

  always @(posedge sclOut) begin
    cap = {cap[7:0], sdaBus};
    capCnt = capCnt + 1;
  end

  always @(negedge sdaBus) if (sclOut === 1'b1) starts = starts + 1;
  always @(posedge sdaBus) if (sclOut === 1'b1) stops = stops + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic ctrl, input logic [7:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrCtrl = ctrl; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic prepBus(input logic [8:0] bits);
    slaveBits = bits; negIdx = 0; capCnt = 0; cap = 9'h0;
  endtask

  // issues a command and returns the number of busy cycles
  task automatic runCmd(input logic [3:0] code, output int cyc);
    regWrite(1'b1, {4'h0, code});
    cyc = 0;
    while (statusOut[6] && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc, s0, p0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    starts = 0; stops = 0;

    // R1 reset state
    check(statusOut == 8'h30, "R1 status", statusOut, 8'h30);
    check(dataOut == 8'h00, "R1 data", dataOut, 0);
    check(sclOut && sdaBus, "R1 bus idle", {sclOut, sdaBus}, 3);

    // R3 start
    prepBus(9'h1FF);
    runCmd(4'h1, cyc);
    check(cyc == SHORT_CYC, "R3 start length", cyc, SHORT_CYC);
    check(starts == 1 && stops == 0, "R3 start seen", starts, 1);
    check(sclOut && !sdaBus, "R3 bus after start", {sclOut, sdaBus}, 2);
    check(statusOut[3:0] == 4'h1 && !statusOut[7], "R2 cmd field", statusOut, 8'h31);

    // R5 R6 send sweep
    for (int b = 0; b < 256; b++) begin
      logic a;
      a = b[0];
      s0 = starts; p0 = stops;
      regWrite(1'b0, b[7:0]);
      prepBus({8'hFF, a});
      runCmd(4'h3, cyc);
      check(cyc == BYTE_CYC, "R5 send length", cyc, BYTE_CYC);
      check(capCnt == 9 && cap == {b[7:0], a}, "R5 send bits", cap, {b[7:0], a});
      check(starts == s0 && stops == p0, "R5 no bus condition", starts + stops, s0 + p0);
      check(statusOut[5] == a, "R6 receive ack status", statusOut[5], a);
      check(statusOut[3:0] == 4'h3, "R2 cmd field send", statusOut[3:0], 3);
    end

    // R3 repeated start after a byte
    s0 = starts;
    prepBus(9'h1FF);
    runCmd(4'h1, cyc);
    check(starts == s0 + 1, "R3 repeated start", starts, s0 + 1);

    // R7 R8 receive sweep
    for (int b = 0; b < 256; b++) begin
      logic nack;
      nack = b[0];
      s0 = starts; p0 = stops;
      prepBus({b[7:0], 1'b1});
      runCmd(nack ? 4'h5 : 4'h4, cyc);
      check(cyc == BYTE_CYC, "R7 receive length", cyc, BYTE_CYC);
      check(dataOut == b[7:0], "R7 received byte", dataOut, b);
      check(capCnt == 9 && cap[0] == nack, "R8 master ack bit", cap[0], nack);
      check(statusOut[4] == nack, "R8 transmit ack status", statusOut[4], nack);
      check(starts == s0 && stops == p0, "R7 no bus condition", starts + stops, s0 + p0);
    end

    // R4 stop
    p0 = stops;
    prepBus(9'h1FF);
    runCmd(4'h2, cyc);
    check(cyc == SHORT_CYC, "R4 stop length", cyc, SHORT_CYC);
    check(stops == p0 + 1, "R4 stop seen", stops, p0 + 1);
    check(sclOut && sdaBus, "R4 bus idle", {sclOut, sdaBus}, 3);

    // R10 illegal codes
    for (int c = 0; c < 16; c++) begin
      if (c >= 1 && c <= 5) continue;
      s0 = starts; p0 = stops;
      regWrite(1'b1, c[7:0]);
      repeat (4) @(negedge clk);
      check(statusOut[7] && !statusOut[6], "R10 illegal flagged", statusOut, 8'h80);
      check(statusOut[3:0] == c[3:0], "R2 illegal code field", statusOut[3:0], c);
      check(sclOut && starts == s0 && stops == p0, "R10 no bus activity", starts + stops, s0 + p0);
    end
    prepBus(9'h1FF);
    runCmd(4'h1, cyc);
    check(!statusOut[7], "R10 legal clears error", statusOut[7], 0);

    // R11 writes while busy
    regWrite(1'b0, 8'hA5);
    prepBus(9'h1FE);
    s0 = starts; p0 = stops;
    regWrite(1'b1, 8'h03);
    repeat (5) @(negedge clk);
    regWrite(1'b1, 8'h02);
    regWrite(1'b0, 8'h3C);
    cyc = 0;
    while (statusOut[6] && cyc < 1000) begin cyc++; @(negedge clk); end
    check(statusOut[7], "R11 busy write error", statusOut[7], 1);
    check(cap == {8'hA5, 1'b0}, "R11 transfer unchanged", cap, {8'hA5, 1'b0});
    check(dataOut == 8'hA5, "R11 data write ignored", dataOut, 8'hA5);
    check(statusOut[3:0] == 4'h3 && stops == p0 && starts == s0, "R11 command ignored", statusOut[3:0], 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule